// File: doc/BRIEF.md
# Bank-Switched Controller Register File

This block is the byte-wide host register file of a small network controller. The host sees 32 byte registers. It presents a byte offset that is first divided by a fixed address stride, so the low address bits are ignored. The block decodes reads and writes and applies a different write rule to each register. Two status registers clear the bits written as 1. The interrupt-enable and configuration registers are plain storage. The control register keeps its identification bits and lets software change only the rest.

Offsets 8 to 15 are steered by a bank-select field in the control register. They reach either the base registers, which hold the station address after reset, or one of two alternate 8-byte banks: a multicast-filter bank and a buffer-port bank. The status bits are set by event inputs from the rest of the controller. Offsets with no register behind them read as zero, ignore writes and raise a one-cycle error pulse. Read data is either combinational or registered, chosen by a parameter.

Top module: `nic_regbank`

## Requirements
- R1: The register index is the host address divided by STRIDE (a power of two). Address bits below the stride do not affect which register is accessed.
- R2: Bits [3:2] of control register 7 select the bank for offsets 8–15: 0 = base registers, 1 = multicast bank, 2 = buffer-port bank, 3 = reserved, which falls through to the base registers.
- R3: Writing offset 0 (transmit status) or offset 1 (receive status) clears each stored bit whose written bit is 1 and leaves the other bits unchanged.
- R4: A 1 on any bit of `tx_evt` or `rx_evt` sets the matching status bit at the next clock edge. When a set and a write-1-to-clear hit the same bit in the same cycle, the set wins.
- R5: A write to offset 7 leaves bits [7:6] (identification) unchanged and loads bits [5:0] from the write data.
- R6: After reset, register 7 holds ID_CODE (0x80 by default, bank select 0). Base offsets 8–13 hold the six STATION bytes, most significant byte at offset 8. Every other register and both alternate banks hold zero.
- R7: Offsets 2, 3 and 6, and base offsets 8–13, are plain read/write bytes. All eight bytes of the multicast bank and of the buffer-port bank are plain read/write bytes.
- R8: Offsets 4, 5, 16–31, and base offsets 14–15 are unimplemented. They read as zero and ignore writes. `acc_err` is high for exactly the one cycle after a read or write to any of them.
- R9: With READ_LAT = 1, `rdata` shows, one clock after the address is presented, the register value held before that clock's write. With READ_LAT = 0, `rdata` follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (used for error reporting) |
| addr | input | ADDR_W | Host byte address, scaled by STRIDE |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| acc_err | output | 1 | One-cycle pulse after an access to an unimplemented offset |
| tx_evt | input | 8 | Transmit status set events |
| rx_evt | input | 8 | Receive status set events |

## Verification
The assertions check several rules on every cycle. The identification bits never change. Reset reloads the identification code. A status bit set by an event is visible on the next cycle. Bits written as 1 to a status register clear when no event collides with them. An error pulse always follows a host access, and an access to a known unimplemented offset always produces one. Bank steering, address scaling, the station-address reset image, and the read and ignore behaviour of every offset in every bank selection can only be shown by the bench's sweeps. These sweeps write and read back all 32 offsets under each of the four bank-select values.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  localparam int REG_AW    = 5;
  localparam int BANK_DEPTH = 8;
  localparam int STA_BYTES = 6;

  typedef enum logic [1:0] {
    BK_BASE  = 2'd0,
    BK_MCAST = 2'd1,
    BK_BUFP  = 2'd2,
    BK_RSVD  = 2'd3
  } bank_e;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_TXST,
    TGT_RXST,
    TGT_TXEN,
    TGT_RXEN,
    TGT_CFG6,
    TGT_CTRL7,
    TGT_STA,
    TGT_MCAST,
    TGT_BUFP
  } tgt_e;
endpackage

// File: rtl/nrb_decode.sv
module nrb_decode
  import nrb_pkg::*;
(
  input  logic [REG_AW-1:0] idx,
  input  bank_e             bsel,
  output tgt_e              tgt,
  output logic [2:0]        sub
);
  always_comb begin
    tgt = TGT_NONE;
    sub = idx[2:0];
    if (!idx[REG_AW-1]) begin
      if (idx[3]) begin
        if (bsel == BK_MCAST)      tgt = TGT_MCAST;
        else if (bsel == BK_BUFP)  tgt = TGT_BUFP;
        else if (idx[2:0] < 3'd6)  tgt = TGT_STA;
      end else begin
        case (idx[2:0])
          3'd0: tgt = TGT_TXST;
          3'd1: tgt = TGT_RXST;
          3'd2: tgt = TGT_TXEN;
          3'd3: tgt = TGT_RXEN;
          3'd6: tgt = TGT_CFG6;
          3'd7: tgt = TGT_CTRL7;
          default: tgt = TGT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nrb_bank_store.sv
module nrb_bank_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nrb_rdstage.sv
module nrb_rdstage #(
  parameter int READ_LAT = 1,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out
);
  generate
    if (READ_LAT == 0) begin : g_comb
      assign d_out = d_in;
    end else begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d_in;
      end
      assign d_out = q;
    end
  endgenerate
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nrb_pkg::*;
#(
  parameter int          STRIDE   = 2,
  parameter int          ADDR_W   = REG_AW + $clog2(STRIDE),
  parameter int          READ_LAT = 1,
  parameter logic [7:0]  ID_MASK  = 8'hC0,
  parameter logic [7:0]  ID_CODE  = 8'h80,
  parameter logic [47:0] STATION  = 48'h0A1B2C3D4E5F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              acc_err,
  input  logic [7:0]        tx_evt,
  input  logic [7:0]        rx_evt
);
  localparam int NBANK = 2;
  localparam int BK_AW = $clog2(BANK_DEPTH);

  logic [REG_AW-1:0] idx;
  tgt_e              tgt;
  logic [2:0]        sub;
  bank_e             bsel;

  logic [7:0] tx_stat_q, rx_stat_q, tx_ien_q, rx_ien_q, cfg6_q, ctrl7_q;
  logic [7:0] sta_q [STA_BYTES];
  logic [7:0] bank_rd [NBANK];
  logic [7:0] rd_mux;
  logic       err_q;

  assign idx  = addr[ADDR_W-1 -: REG_AW];
  assign bsel = bank_e'(ctrl7_q[3:2]);

  nrb_decode u_dec (
    .idx  (idx),
    .bsel (bsel),
    .tgt  (tgt),
    .sub  (sub)
  );

  // Status: events set, host writes of 1 clear; set wins on collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_stat_q <= '0;
      rx_stat_q <= '0;
    end else begin
      tx_stat_q <= (tx_stat_q & ~((wr_en && tgt == TGT_TXST) ? wdata : 8'h00)) | tx_evt;
      rx_stat_q <= (rx_stat_q & ~((wr_en && tgt == TGT_RXST) ? wdata : 8'h00)) | rx_evt;
    end
  end

  // Plain storage and the protected control register.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ien_q <= '0;
      rx_ien_q <= '0;
      cfg6_q   <= '0;
      ctrl7_q  <= ID_CODE & ID_MASK;
    end else if (wr_en) begin
      case (tgt)
        TGT_TXEN:  tx_ien_q <= wdata;
        TGT_RXEN:  rx_ien_q <= wdata;
        TGT_CFG6:  cfg6_q   <= wdata;
        TGT_CTRL7: ctrl7_q  <= (ctrl7_q & ID_MASK) | (wdata & ~ID_MASK);
        default: ;
      endcase
    end
  end

  // Station address bytes, loaded from the parameter on reset.
  generate
    for (genvar k = 0; k < STA_BYTES; k++) begin : g_sta
      always_ff @(posedge clk) begin
        if (rst)
          sta_q[k] <= STATION[47-8*k -: 8];
        else if (wr_en && tgt == TGT_STA && sub == 3'(k))
          sta_q[k] <= wdata;
      end
    end
  endgenerate

  // Alternate banks behind offsets 8..15.
  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic bank_we;
      assign bank_we = wr_en && (tgt == ((g == 0) ? TGT_MCAST : TGT_BUFP));
      nrb_bank_store #(.DEPTH(BANK_DEPTH), .DW(8)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (bank_we),
        .waddr (sub[BK_AW-1:0]),
        .wdata (wdata),
        .raddr (sub[BK_AW-1:0]),
        .rdata (bank_rd[g])
      );
    end
  endgenerate

  always_comb begin
    case (tgt)
      TGT_TXST:  rd_mux = tx_stat_q;
      TGT_RXST:  rd_mux = rx_stat_q;
      TGT_TXEN:  rd_mux = tx_ien_q;
      TGT_RXEN:  rd_mux = rx_ien_q;
      TGT_CFG6:  rd_mux = cfg6_q;
      TGT_CTRL7: rd_mux = ctrl7_q;
      TGT_STA:   rd_mux = (sub < 3'(STA_BYTES)) ? sta_q[sub] : 8'h00;
      TGT_MCAST: rd_mux = bank_rd[0];
      TGT_BUFP:  rd_mux = bank_rd[1];
      default:   rd_mux = 8'h00;
    endcase
  end

  nrb_rdstage #(.READ_LAT(READ_LAT), .DW(8)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rd_mux),
    .d_out (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (wr_en || rd_en) && (tgt == TGT_NONE);
  end
  assign acc_err = err_q;
endmodule

// File: rtl/nrb_checker.sv
module nrb_checker #(
  parameter logic [7:0] ID_MASK = 8'hC0,
  parameter logic [7:0] ID_CODE = 8'h80
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [4:0] idx,
  input logic [7:0] wdata,
  input logic [7:0] tx_evt,
  input logic [7:0] rx_evt,
  input logic [7:0] tx_stat,
  input logic [7:0] rx_stat,
  input logic [7:0] ctrl7,
  input logic       acc_err
);
  // R3: bits written as 1 are clear next cycle when no event collides
  p_w1c_tx_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == 5'd0 && tx_evt == 8'h00) |=> ((tx_stat & $past(wdata)) == 8'h00));
  p_w1c_rx_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == 5'd1 && rx_evt == 8'h00) |=> ((rx_stat & $past(wdata)) == 8'h00));

  // R4: events are captured the following cycle
  p_set_tx_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_evt != 8'h00) |=> ((tx_stat & $past(tx_evt)) == $past(tx_evt)));
  p_set_rx_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_evt != 8'h00) |=> ((rx_stat & $past(rx_evt)) == $past(rx_evt)));

  // R5: identification bits never move
  p_id_keep_r5: assert property (@(posedge clk) disable iff (rst)
    ((ctrl7 & ID_MASK) == (ID_CODE & ID_MASK)));

  // R6: reset reloads the identification code
  p_reset_id_r6: assert property (@(posedge clk)
    rst |=> (ctrl7 == (ID_CODE & ID_MASK)));

  // R8: an error pulse always follows a host access
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(wr_en || rd_en));
  p_err_hole_r8: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && (idx == 5'd4 || idx == 5'd5 || idx[4])) |=> acc_err);
endmodule

bind nic_regbank nrb_checker #(.ID_MASK(ID_MASK), .ID_CODE(ID_CODE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .idx     (idx),
  .wdata   (wdata),
  .tx_evt  (tx_evt),
  .rx_evt  (rx_evt),
  .tx_stat (tx_stat_q),
  .rx_stat (rx_stat_q),
  .ctrl7   (ctrl7_q),
  .acc_err (acc_err)
);

// File: tb/test_nic_regbank.sv
`timescale 1ns/1ps
module test_nic_regbank;
  localparam int          STRIDE = 2;
  localparam int          AW     = 6;
  localparam logic [47:0] STA    = 48'h0A1B2C3D4E5F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic acc_err;
  logic [7:0] tx_evt = '0, rx_evt = '0;

  int n_tests = 0, n_fail = 0;

  logic [7:0] m_base [32];
  logic [7:0] m_mc [8];
  logic [7:0] m_bp [8];

  always #2 clk = ~clk;

  nic_regbank #(.STRIDE(STRIDE), .READ_LAT(1), .STATION(STA)) i_nic_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .acc_err(acc_err),
    .tx_evt(tx_evt), .rx_evt(rx_evt)
  );

  function automatic int bsel_m();
    return int'(m_base[7][3:2]);
  endfunction

  function automatic bit impl_m(int i);
    if (i < 8) return (i != 4 && i != 5);
    if (i < 16) return (bsel_m() == 1 || bsel_m() == 2 || i < 14);
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_rd(int i);
    if (!impl_m(i)) return 8'h00;
    if (i >= 8 && i < 16 && bsel_m() == 1) return m_mc[i-8];
    if (i >= 8 && i < 16 && bsel_m() == 2) return m_bp[i-8];
    return m_base[i];
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic apply_wr(int i, logic [7:0] w);
    if (!impl_m(i)) return;
    if (i == 0 || i == 1) m_base[i] = m_base[i] & ~w;
    else if (i == 7) m_base[7] = (m_base[7] & 8'hC0) | (w & 8'h3F);
    else if (i >= 8 && bsel_m() == 1) m_mc[i-8] = w;
    else if (i >= 8 && bsel_m() == 2) m_bp[i-8] = w;
    else m_base[i] = w;
  endtask

  // R1: the low address bit is don't-care with STRIDE 2
  task automatic do_write(int i, logic [7:0] w, logic lowbit);
    bit imp;
    imp = impl_m(i);
    @(negedge clk);
    addr = {i[4:0], lowbit};
    wdata = w;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(acc_err == !imp, "R8 write err flag", {7'd0, acc_err}, {7'd0, !imp});
    apply_wr(i, w);
  endtask

  task automatic do_read(int i, logic lowbit, string req);
    logic [7:0] e;
    bit imp;
    e = exp_rd(i);
    imp = impl_m(i);
    @(negedge clk);
    addr = {i[4:0], lowbit};
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rdata == e, req, rdata, e);
    chk(acc_err == !imp, "R8 read err flag", {7'd0, acc_err}, {7'd0, !imp});
  endtask

  task automatic pulse_evt(logic [7:0] t, logic [7:0] r);
    @(negedge clk);
    tx_evt = t;
    rx_evt = r;
    @(negedge clk);
    tx_evt = '0;
    rx_evt = '0;
    m_base[0] = m_base[0] | t;
    m_base[1] = m_base[1] | r;
  endtask

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 0x00 expected 0x01");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_base[i] = 8'h00;
    for (int i = 0; i < 8; i++) begin m_mc[i] = 8'h00; m_bp[i] = 8'h00; end
    m_base[7] = 8'h80;
    for (int k = 0; k < 6; k++) m_base[8+k] = STA[47-8*k -: 8];

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R6: reset image of every offset
    for (int i = 0; i < 32; i++) do_read(i, 1'b0, "R6 reset value");

    // R4: events set status bits
    pulse_evt(8'hA5, 8'h3C);
    do_read(0, 1'b0, "R4 tx status set");
    do_read(1, 1'b1, "R4 rx status set");

    // R3: partial clear
    do_write(0, 8'h81, 1'b0);
    do_read(0, 1'b0, "R3 tx partial clear");

    // R4: set wins against a same-cycle clear
    @(negedge clk);
    addr = {5'd0, 1'b0};
    wdata = 8'hFF;
    wr_en = 1'b1;
    tx_evt = 8'h0F;
    @(negedge clk);
    wr_en = 1'b0;
    tx_evt = 8'h00;
    m_base[0] = 8'h0F;
    do_read(0, 1'b0, "R4 set beats clear");

    // R5: identification bits survive a full write
    do_write(7, 8'h33, 1'b1);
    do_read(7, 1'b0, "R5 ctrl7 protected id");
    do_write(7, 8'hC0, 1'b0);
    do_read(7, 1'b1, "R5 ctrl7 cleared low bits");

    // R8: error flag is a single-cycle pulse
    do_write(20, 8'h55, 1'b0);
    @(negedge clk);
    chk(acc_err == 1'b0, "R8 err pulse width", {7'd0, acc_err}, 8'h00);

    // R2, R7, R8, R1: sweep all offsets under every bank selection
    for (int b = 0; b < 4; b++) begin
      pulse_evt(8'hFF, 8'hFF);
      do_write(7, {2'b01, 2'b10, b[1:0], 2'b01}, b[0]);
      for (int i = 0; i < 32; i++) begin
        if (i != 7) do_write(i, 8'((i * 37 + b * 11 + 5) & 8'hFF), i[0] ^ b[0]);
      end
      for (int i = 0; i < 32; i++) do_read(i, i[1], "R2 R7 bank sweep readback");
    end

    // R2: reserved encoding reaches base station bytes again
    do_write(7, 8'h0C, 1'b0);
    for (int i = 8; i < 16; i++) do_read(i, 1'b1, "R2 reserved falls to base");
    do_write(7, 8'h04, 1'b0);
    for (int i = 8; i < 16; i++) do_read(i, 1'b0, "R2 multicast bank retained");

    // R9: back-to-back reads, one cycle of latency each
    do_write(2, 8'h5A, 1'b0);
    do_write(3, 8'hC3, 1'b0);
    @(negedge clk);
    addr = {5'd2, 1'b0};
    rd_en = 1'b1;
    @(negedge clk);
    chk(rdata == 8'h5A, "R9 first of pair", rdata, 8'h5A);
    addr = {5'd3, 1'b0};
    @(negedge clk);
    rd_en = 1'b0;
    chk(rdata == 8'hC3, "R9 second of pair", rdata, 8'hC3);

    // R9: a read in the same cycle as a write returns the old value
    @(negedge clk);
    addr = {5'd6, 1'b0};
    wdata = 8'hE7;
    wr_en = 1'b1;
    rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    chk(rdata == m_base[6], "R9 read before write", rdata, m_base[6]);
    m_base[6] = 8'hE7;
    do_read(6, 1'b1, "R9 write then visible");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule